// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Mask Level

This block gathers a set of level-sensitive interrupt sources and one non-maskable input and hands the CPU at most one interrupt at a time. Each source carries its own 4-bit priority. A level of 0 turns the source off. Among the sources that are requesting, the one with the highest level is picked. That level must be strictly above the controller's current 4-bit mask level, or the request waits.

When a request is accepted, the mask level is raised to the winner's priority and an acceptance sequence starts. The active-low `irqout_n` pin goes low and the CPU is asked to save its status and program counter. The CPU reports the end of that save with `save_done`, and `irqout_n` then returns high. The controller then presents the vector number until the CPU acknowledges the vector read. The CPU can reload the mask level, for example when it returns from a handler.

The non-maskable input first passes through a digital filter. The filter length is programmable. A rising edge that survives the filter is remembered and is served ahead of any maskable source, whatever the mask level.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irqout_n` is 1, `irq_req` and `vec_valid` are 0, and `mask_level` is 15.
- R2: A maskable source is accepted only if it is requesting and its priority is strictly greater than `mask_level`. A source with priority 0 is never accepted.
- R3: Among the eligible sources, the highest priority wins. When priorities are equal, the lowest source index wins.
- R4: The vector for source i is VEC_BASE + i. The vector for the non-maskable input is VEC_BASE + NUM_SRC (72 with the default parameters).
- R5: On acceptance, `mask_level` takes the priority of the accepted source. For the non-maskable input it takes 15.
- R6: `irqout_n` goes low and `irq_req` goes high on the clock edge that accepts a request. Both stay there until the edge that samples `save_done`. At that edge `irqout_n` returns high and `vec_valid` goes high.
- R7: While `vec_valid` is high, `vec_num` holds its value. `vec_valid` drops on the edge that samples `vec_ack`, and the controller is then idle.
- R8: The non-maskable input counts only when its synchronised value differs from the filtered value for `nmi_filt_len` consecutive clocks. A length of 0 acts as 1. Only a rising filtered edge raises a request, so holding the input high or a falling edge raises none.
- R9: A filtered non-maskable request ignores the mask level. If it is pending in the same cycle as an eligible maskable source, the non-maskable request wins.
- R10: A non-maskable edge that arrives during an acceptance sequence is kept pending. It is accepted on the first idle cycle after the sequence ends.
- R11: A `mask_wr_en` pulse loads `mask_wr_val` into `mask_level` only when the controller is idle and accepts nothing in that cycle. Outside that case the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_req | input | NUM_SRC | Level request of each source |
| src_prio | input | 4*NUM_SRC | Priority of each source; source i uses bits [4i+3:4i] |
| nmi_in | input | 1 | Raw non-maskable input (asynchronous) |
| nmi_filt_len | input | FILT_W | Number of stable clocks the filter requires |
| mask_wr_en | input | 1 | CPU write strobe for the mask level |
| mask_wr_val | input | 4 | Mask level to load |
| save_done | input | 1 | CPU has finished saving status and program counter |
| vec_ack | input | 1 | CPU has read the vector |
| irq_req | output | 1 | Interrupt request to the CPU (save phase) |
| irqout_n | output | 1 | Active-low acceptance indicator pin |
| vec_valid | output | 1 | Vector number is valid |
| vec_num | output | VEC_W | Vector number of the accepted interrupt |
| mask_level | output | 4 | Current mask level |

## Verification
The main collision is a filtered non-maskable edge and an eligible maskable source reaching the idle acceptance point in the same cycle. The bench first measures the filter and pending-latch latency from a clean non-maskable pulse. It then raises a priority-15 source exactly one clock before the predicted acceptance edge, with the mask at 0. A correct result is the non-maskable vector with the mask at 15. The other collision is a CPU mask write in the very cycle a source is accepted: the accepted priority must end up in `mask_level`, not the written value.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
    localparam int LVL_W   = 4;
    localparam int LVL_MAX = (1 << LVL_W) - 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SAVE = 2'd1,
        ST_VEC  = 2'd2
    } acc_state_e;
endpackage

// File: rtl/nmi_glitch_filter.sv
module nmi_glitch_filter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             rise_o
);
    typedef struct packed {
        logic             s1;
        logic             s2;
        logic             stable;
        logic [CNT_W-1:0] cnt;
        logic             rise;
    } flt_t;

    flt_t flt_d, flt_q;
    logic [CNT_W:0] need;
    logic [CNT_W:0] seen;

    always_comb begin
        flt_d      = flt_q;
        flt_d.s1   = raw_i;
        flt_d.s2   = flt_q.s1;
        flt_d.rise = 1'b0;
        // A length of 0 behaves like a length of 1.
        need = (len_i == '0) ? (CNT_W+1)'(1) : {1'b0, len_i};
        seen = {1'b0, flt_q.cnt} + (CNT_W+1)'(1);
        if (flt_q.s2 == flt_q.stable) begin
            flt_d.cnt = '0;
        end else if (seen >= need) begin
            flt_d.stable = flt_q.s2;
            flt_d.cnt    = '0;
            flt_d.rise   = flt_q.s2;
        end else begin
            flt_d.cnt = seen[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flt_q <= '0;
        else        flt_q <= flt_d;
    end

    assign rise_o = flt_q.rise;
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = 3
) (
    input  logic [NUM_SRC-1:0]   req_i,
    input  logic [NUM_SRC*4-1:0] prio_i,
    output logic                 hit_o,
    output logic [IDX_W-1:0]     idx_o,
    output logic [3:0]           lvl_o
);
    logic [3:0] lvl_arr [NUM_SRC];

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_unpack
        assign lvl_arr[g] = req_i[g] ? prio_i[g*4 +: 4] : 4'd0;
    end

    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        lvl_o = 4'd0;
        // Strict comparison keeps the lowest index on a tie.
        for (int i = 0; i < NUM_SRC; i++) begin
            if (lvl_arr[i] > lvl_o) begin
                hit_o = 1'b1;
                idx_o = IDX_W'(i);
                lvl_o = lvl_arr[i];
            end
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC  = 8,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 64,
    parameter int FILT_W   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   src_req,
    input  logic [NUM_SRC*4-1:0] src_prio,
    input  logic                 nmi_in,
    input  logic [FILT_W-1:0]    nmi_filt_len,
    input  logic                 mask_wr_en,
    input  logic [3:0]           mask_wr_val,
    input  logic                 save_done,
    input  logic                 vec_ack,
    output logic                 irq_req,
    output logic                 irqout_n,
    output logic                 vec_valid,
    output logic [VEC_W-1:0]     vec_num,
    output logic [3:0]           mask_level
);
    localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int NMI_VEC = VEC_BASE + NUM_SRC;

    typedef struct packed {
        acc_state_e       state;
        logic [3:0]       mask;
        logic [VEC_W-1:0] vec;
        logic             nmi_pend;
    } ctl_t;

    ctl_t       ctl_d, ctl_q;
    logic       nmi_rise;
    logic       pick_hit;
    logic [IDX_W-1:0] pick_idx;
    logic [3:0] pick_lvl;

    nmi_glitch_filter #(.CNT_W(FILT_W)) u_nmi_flt (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (nmi_in),
        .len_i  (nmi_filt_len),
        .rise_o (nmi_rise)
    );

    prio_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pick (
        .req_i  (src_req),
        .prio_i (src_prio),
        .hit_o  (pick_hit),
        .idx_o  (pick_idx),
        .lvl_o  (pick_lvl)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (nmi_rise) ctl_d.nmi_pend = 1'b1;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (ctl_q.nmi_pend) begin
                    ctl_d.state    = ST_SAVE;
                    ctl_d.mask     = 4'(LVL_MAX);
                    ctl_d.vec      = VEC_W'(NMI_VEC);
                    ctl_d.nmi_pend = nmi_rise;
                end else if (pick_hit && (pick_lvl > ctl_q.mask)) begin
                    ctl_d.state = ST_SAVE;
                    ctl_d.mask  = pick_lvl;
                    ctl_d.vec   = VEC_W'(VEC_BASE) + VEC_W'(pick_idx);
                end else if (mask_wr_en) begin
                    ctl_d.mask = mask_wr_val;
                end
            end
            ST_SAVE: if (save_done) ctl_d.state = ST_VEC;
            ST_VEC:  if (vec_ack)   ctl_d.state = ST_IDLE;
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state    <= ST_IDLE;
            ctl_q.mask     <= 4'(LVL_MAX);
            ctl_q.vec      <= '0;
            ctl_q.nmi_pend <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign irq_req    = (ctl_q.state == ST_SAVE);
    assign irqout_n   = (ctl_q.state != ST_SAVE);
    assign vec_valid  = (ctl_q.state == ST_VEC);
    assign vec_num    = ctl_q.vec;
    assign mask_level = ctl_q.mask;
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mask_wr_en,
    input logic             vec_ack,
    input logic             irq_req,
    input logic             irqout_n,
    input logic             vec_valid,
    input logic [VEC_W-1:0] vec_num,
    input logic [3:0]       mask_level
);
    // R7
    vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && !vec_ack) |=> (vec_valid && $stable(vec_num)));

    // R5
    mask_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irqout_n) |-> ((mask_level > $past(mask_level)) || (mask_level == 4'd15)));

    // R6
    pin_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irqout_n) |-> vec_valid);

    // R6
    phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (irqout_n && !irq_req));

    // R11
    busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irqout_n && mask_wr_en) |=> $stable(mask_level));

    // R6
    start_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irqout_n) |-> !$past(vec_valid));
endmodule

bind prio_irq_ctrl prio_irq_chk #(.VEC_W(VEC_W)) u_prio_irq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mask_wr_en (mask_wr_en),
    .vec_ack    (vec_ack),
    .irq_req    (irq_req),
    .irqout_n   (irqout_n),
    .vec_valid  (vec_valid),
    .vec_num    (vec_num),
    .mask_level (mask_level)
);

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
    localparam int N    = 8;
    localparam int VW   = 8;
    localparam int BASE = 64;
    localparam int NMIV = BASE + N;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src_req = '0;
    logic [N*4-1:0] src_prio = '0;
    logic          nmi_in = 1'b0;
    logic [3:0]    nmi_filt_len = 4'd4;
    logic          mask_wr_en = 1'b0;
    logic [3:0]    mask_wr_val = '0;
    logic          save_done = 1'b0;
    logic          vec_ack = 1'b0;
    logic          irq_req, irqout_n, vec_valid;
    logic [VW-1:0] vec_num;
    logic [3:0]    mask_level;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    prio_irq_ctrl #(.NUM_SRC(N), .VEC_W(VW), .VEC_BASE(BASE), .FILT_W(4)) u_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_prio(src_prio),
        .nmi_in(nmi_in), .nmi_filt_len(nmi_filt_len), .mask_wr_en(mask_wr_en),
        .mask_wr_val(mask_wr_val), .save_done(save_done), .vec_ack(vec_ack),
        .irq_req(irq_req), .irqout_n(irqout_n), .vec_valid(vec_valid),
        .vec_num(vec_num), .mask_level(mask_level)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected winner: highest level above mask, lowest index on tie (R2, R3).
    function automatic int model_pick(input logic [N-1:0] r, input logic [N*4-1:0] p,
                                      input int mask, output int lvl);
        int best = -1;
        lvl = 0;
        for (int i = 0; i < N; i++) begin
            int l = int'(p[i*4 +: 4]);
            if (r[i] && l > lvl) begin
                lvl = l;
                best = i;
            end
        end
        if (lvl <= mask) best = -1;
        return best;
    endfunction

    task automatic write_mask(input int v);
        @(negedge clk);
        mask_wr_en = 1'b1; mask_wr_val = 4'(v);
        @(negedge clk);
        mask_wr_en = 1'b0;
    endtask

    // Called at the negedge after the accepting edge.
    task automatic finish_seq(input int ev, input int em, input string tag);
        mask_wr_en = 1'b0;
        check(irqout_n == 1'b0 && irq_req == 1'b1, "R6", irqout_n, 0);
        check(mask_level == 4'(em), tag, mask_level, em);
        save_done = 1'b1; src_req = '0;
        @(negedge clk);
        save_done = 1'b0;
        check(irqout_n == 1'b1 && vec_valid == 1'b1, "R6", vec_valid, 1);
        check(vec_num == VW'(ev), tag, vec_num, ev);
        @(negedge clk);
        check(vec_valid == 1'b1 && vec_num == VW'(ev), "R7", vec_num, ev);
        vec_ack = 1'b1;
        @(negedge clk);
        vec_ack = 1'b0;
        check(vec_valid == 1'b0 && irqout_n == 1'b1, "R7", vec_valid, 0);
    endtask

    task automatic accept_seq(input int ev, input int em, input string tag);
        @(negedge clk);
        finish_seq(ev, em, tag);
    endtask

    task automatic quiet_window(input int n, input string tag);
        int low = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!irqout_n) low++;
        end
        check(low == 0, tag, low, 0);
    endtask

    initial begin
        int k;
        int lvl;
        int w;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        // R1: state while in reset and right after release
        check(irqout_n && !irq_req && !vec_valid && mask_level == 4'd15, "R1", mask_level, 15);
        rst_n = 1'b1;
        @(negedge clk);
        check(irqout_n && !irq_req && !vec_valid && mask_level == 4'd15, "R1", mask_level, 15);

        // R2: the reset mask blocks even priority 15
        src_req = 8'h01; src_prio = 32'h0000_000F;
        quiet_window(3, "R2");
        src_req = '0;

        // R11: idle write loads the mask
        write_mask(3);
        check(mask_level == 4'd3, "R11", mask_level, 3);

        // R3: tie between sources 2 and 5 at level 7 goes to 2
        @(negedge clk);
        src_prio = '0; src_prio[2*4 +: 4] = 4'd7; src_prio[5*4 +: 4] = 4'd7;
        src_req = 8'b0010_0100;
        accept_seq(BASE + 2, 7, "R3");

        // R2: priority equal to mask is refused; priority 0 never accepted
        write_mask(0);
        @(negedge clk);
        src_prio = '0; src_req = 8'h10;
        quiet_window(3, "R2");
        write_mask(6);
        @(negedge clk);
        src_prio[4*4 +: 4] = 4'd6;
        quiet_window(3, "R2");
        src_req = '0;

        // R11: write in the acceptance cycle loses; write during save is ignored
        write_mask(2);
        @(negedge clk);
        src_prio = '0; src_prio[0 +: 4] = 4'd9; src_req = 8'h01;
        mask_wr_en = 1'b1; mask_wr_val = 4'd0;
        @(negedge clk);
        check(mask_level == 4'd9, "R11", mask_level, 9);
        finish_seq(BASE + 0, 9, "R5");

        // Random mix against the model (R2, R3, R4, R5)
        for (int it = 0; it < 40; it++) begin
            logic [N-1:0]   r;
            logic [N*4-1:0] p;
            int m;
            r = N'($urandom);
            p = $urandom;
            m = int'($urandom_range(0, 14));
            write_mask(m);
            w = model_pick(r, p, m, lvl);
            @(negedge clk);
            src_req = r; src_prio = p;
            if (w >= 0) begin
                accept_seq(BASE + w, lvl, "R4");
            end else begin
                @(negedge clk);
                check(irqout_n == 1'b1 && mask_level == 4'(m), "R2", mask_level, m);
                src_req = '0;
            end
        end

        // R8: short glitch is filtered out
        write_mask(0);
        nmi_filt_len = 4'd4;
        @(negedge clk);
        nmi_in = 1'b1;
        repeat (2) @(negedge clk);
        nmi_in = 1'b0;
        quiet_window(14, "R8");

        // R8: held input raises one request; measure latency
        nmi_in = 1'b1;
        k = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            k++;
            if (!irqout_n) break;
        end
        check(irqout_n == 1'b0, "R8", irqout_n, 0);
        finish_seq(NMIV, 15, "R4");
        quiet_window(12, "R8");
        nmi_in = 1'b0;
        quiet_window(12, "R8");

        // R9: NMI and priority-15 source reach the idle point together
        write_mask(0);
        @(negedge clk);
        nmi_in = 1'b1;
        for (int i = 0; i < k - 1; i++) @(negedge clk);
        src_prio = '0; src_prio[3*4 +: 4] = 4'd15; src_req = 8'h08;
        accept_seq(NMIV, 15, "R9");
        nmi_in = 1'b0;
        quiet_window(12, "R9");

        // R10: NMI edge during a save phase is held pending
        write_mask(0);
        @(negedge clk);
        src_prio = '0; src_prio[1*4 +: 4] = 4'd5; src_req = 8'h02;
        @(negedge clk);
        nmi_in = 1'b1;
        repeat (12) @(negedge clk);
        finish_seq(BASE + 1, 5, "R10");
        accept_seq(NMIV, 15, "R10");
        nmi_in = 1'b0;
        quiet_window(12, "R10");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule